// File: doc/BRIEF.md
# Thermometer-to-Gray-to-Binary Output Encoder

This block is the digital back end of a flash converter. It takes the thermometer word produced by a row of comparators and turns it into a Gray code, registers that Gray code, and then turns the registered Gray value into a plain binary count. Every comparator bit is wired into exactly one Gray bit. A comparator that resolves late, or resolves differently in different places, can therefore change at most one Gray bit. It cannot disturb several decoding gates at once.

The resolution `B` is a parameter (default 3, giving a 7-bit thermometer word). The Gray logic is built by a generate structure that scales with `B`. A strobe input marks the cycles on which a new sample is taken. The registered Gray word and its binary equivalent are both visible at the ports. A valid flag follows the strobe one cycle later.

Top module: `tgb_encoder`

## Requirements
- R1: While `rst_n` is low, `gray_o`, `bin_o` and `vld_o` are all zero.
- R2: Input bit `therm_i[j-1]` is comparator level Tj (j = 1..2^B-1). The most significant Gray bit `gray_o[B-1]` equals the level at the middle position T(2^(B-1)); for B=3 this is T4.
- R3: Each lower Gray bit `gray_o[i]` (i < B-1) is the OR, over m ≥ 0, of T((4m+1)·2^i) AND NOT T((4m+3)·2^i). For B=3 this gives G2 = T2 & ~T6 and G1 = (T1 & ~T3) | (T5 & ~T7). This holds for any input word, including words that are not clean thermometer codes.
- R4: Every thermometer bit feeds exactly one Gray bit. Inverting any single input bit changes at most one bit of the captured Gray word.
- R5: A clean thermometer word with its k lowest bits set captures Gray value k ^ (k >> 1). All zeros gives 000, all ones gives 100, and T1..T4 gives 110.
- R6: `bin_o` is the binary decode of the registered Gray word: the top bit is copied, and each lower bit is the XOR of the binary bit above it and the Gray bit at its own position. A clean word of k ones yields `bin_o` = k.
- R7: The Gray register loads on a rising clock edge only when `strobe_i` is high. Otherwise `gray_o` and `bin_o` keep their previous values.
- R8: `vld_o` equals the value `strobe_i` had at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| therm_i | input | 2^B-1 | Comparator levels; bit j-1 is level Tj |
| strobe_i | input | 1 | Sample enable for the Gray register |
| gray_o | output | B | Registered Gray code |
| bin_o | output | B | Binary decode of `gray_o` |
| vld_o | output | 1 | Strobe delayed by one cycle |

## Verification
The hardest case to reach from the ports is the one the encoder exists for: a comparator row whose output is not a clean thermometer word, either because one level has resolved the wrong way or because a stray bit has fired far from the transition point. Random words seldom sit exactly one bit away from a clean code. The stimulus therefore takes every clean code and inverts each bit position in turn. It checks that the captured Gray word follows the per-bit rules and differs from the clean Gray value in at most one bit. Seeded random words and strobe patterns then cover hold behaviour and arbitrary, heavily corrupted inputs.

// File: rtl/tgb_pkg.sv
package tgb_pkg;
  localparam int MAXW = 16;

  // Gray to binary: copy the top bit, then chain XORs downward.
  function automatic logic [MAXW-1:0] gray_to_bin(input logic [MAXW-1:0] g, input int w);
    logic [MAXW-1:0] b;
    b = '0;
    for (int i = MAXW - 1; i >= 0; i--) begin
      if (i == w - 1)  b[i] = g[i];
      else if (i < w)  b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // Reflected Gray code of a count.
  function automatic logic [MAXW-1:0] count_to_gray(input logic [MAXW-1:0] k);
    return k ^ (k >> 1);
  endfunction
endpackage

// File: rtl/tgb_gray_logic.sv
module tgb_gray_logic #(
  parameter int B = 3
) (
  input  logic [(1<<B)-2:0] therm_i,
  output logic [B-1:0]      gray_o
);
  localparam int N   = (1 << B) - 1;
  localparam int MID = 1 << (B - 1);

  // R2: top Gray bit taken from the middle comparator only.
  assign gray_o[B-1] = therm_i[MID-1];

  // R3: each lower level pairs comparators at (4m+1)*2^i and (4m+3)*2^i.
  for (genvar i = 0; i < B - 1; i++) begin : g_level
    localparam int NT = 1 << (B - 2 - i);
    logic [NT-1:0] term_w;
    for (genvar m = 0; m < NT; m++) begin : g_term
      localparam int P = (4*m + 1) << i;
      localparam int Q = (4*m + 3) << i;
      assign term_w[m] = therm_i[P-1] & ~therm_i[Q-1];
    end
    assign gray_o[i] = |term_w;
  end

  initial begin
    assert_width_R2: assert (B >= 2 && B <= 8 && N == 2*MID - 1)
      else $error("unsupported resolution");
  end
endmodule

// File: rtl/tgb_gray_stage.sv
module tgb_gray_stage #(
  parameter int B = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [B-1:0] gray_d_i,
  output logic [B-1:0] gray_q_o,
  output logic         vld_q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gray_q_o <= '0;
      vld_q_o  <= 1'b0;
    end else begin
      vld_q_o <= load_i;
      if (load_i) gray_q_o <= gray_d_i;
    end
  end
endmodule

// File: rtl/tgb_gray2bin.sv
module tgb_gray2bin #(
  parameter int B = 3
) (
  input  logic [B-1:0] gray_i,
  output logic [B-1:0] bin_o
);
  import tgb_pkg::*;
  logic [MAXW-1:0] wide_w;

  always_comb begin
    wide_w = gray_to_bin(MAXW'(gray_i), B);
    bin_o  = wide_w[B-1:0];
  end
endmodule

// File: rtl/tgb_encoder.sv
module tgb_encoder #(
  parameter int B = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [(1<<B)-2:0] therm_i,
  input  logic              strobe_i,
  output logic [B-1:0]      gray_o,
  output logic [B-1:0]      bin_o,
  output logic              vld_o
);
  import tgb_pkg::*;
  localparam int N   = (1 << B) - 1;
  localparam int MID = 1 << (B - 1);

  logic [B-1:0] gray_next_w;

  tgb_gray_logic #(.B(B)) u_logic (
    .therm_i (therm_i),
    .gray_o  (gray_next_w)
  );

  tgb_gray_stage #(.B(B)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (strobe_i),
    .gray_d_i (gray_next_w),
    .gray_q_o (gray_o),
    .vld_q_o  (vld_o)
  );

  tgb_gray2bin #(.B(B)) u_dec (
    .gray_i (gray_o),
    .bin_o  (bin_o)
  );

  // Observation wires for the assertions.
  logic         armed_q;
  logic         clean_w;
  logic [B-1:0] clean_gray_w;
  logic [MAXW-1:0] ones_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  always_comb begin
    clean_w      = ((therm_i & N'(therm_i + N'(1))) == '0);
    ones_w       = MAXW'($countones(therm_i));
    clean_gray_w = B'(count_to_gray(ones_w));
  end

  assert_vld_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (vld_o == $past(strobe_i)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !$past(strobe_i)) |-> $stable(gray_o));

  assert_clean_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(strobe_i) && $past(clean_w)) |-> (gray_o == $past(clean_gray_w)));

  assert_top_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(strobe_i)) |-> (gray_o[B-1] == $past(therm_i[MID-1])));

  assert_decode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_o[B-1] == gray_o[B-1]) && (bin_o[0] == ^gray_o));
endmodule

// File: tb/sim_tgb_encoder.sv
`timescale 1ns/1ps
module sim_tgb_encoder;
  localparam int B = 3;
  localparam int N = (1 << B) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] therm = '0;
  logic         strobe = 1'b0;
  logic [B-1:0] gray_o, bin_o;
  logic         vld_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [B-1:0] exp_gray = '0;

  always #2 clk = ~clk;  // 250 MHz

  tgb_encoder #(.B(B)) u0 (
    .clk(clk), .rst_n(rst_n), .therm_i(therm), .strobe_i(strobe),
    .gray_o(gray_o), .bin_o(bin_o), .vld_o(vld_o)
  );

  // Reference: walk every comparator index, find its level by trailing zeros.
  function automatic logic [B-1:0] ref_gray(input logic [N-1:0] t);
    logic [B-1:0] g = '0;
    g[B-1] = t[(1 << (B-1)) - 1];
    for (int p = 1; p <= N; p++) begin
      int lvl = 0;
      while (((p >> lvl) & 1) == 0) lvl++;
      if (lvl < B - 1 && (p % (1 << (lvl + 2))) == (1 << lvl))
        if (t[p-1] && !t[p + (1 << (lvl + 1)) - 1]) g[lvl] = 1'b1;
    end
    return g;
  endfunction

  function automatic logic [B-1:0] ref_bin(input logic [B-1:0] g);
    logic [B-1:0] b = g;
    for (int s = 1; s < B; s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction

  function automatic logic [N-1:0] clean_word(input int k);
    return N'((1 << k) - 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] t, input logic s);
    @(negedge clk);
    therm  = t;
    strobe = s;
    @(posedge clk);
    #1;
    if (s) exp_gray = ref_gray(t);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1234);

    // R1: outputs stay zero under reset even with strobe and all levels high.
    therm = '1; strobe = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 gray", int'(gray_o), 0);
    check("R1 bin",  int'(bin_o), 0);
    check("R1 vld",  int'(vld_o), 0);
    @(negedge clk);
    rst_n = 1'b1; strobe = 1'b0; therm = '0;
    @(posedge clk); #1;

    // R5, R6, R2, R8: every clean code.
    for (int k = 0; k <= N; k++) begin
      apply(clean_word(k), 1'b1);
      check("R5 clean gray", int'(gray_o), (k ^ (k >> 1)));
      check("R6 clean bin",  int'(bin_o), k);
      check("R2 top gray bit", int'(gray_o[B-1]), int'(k >= (1 << (B-1))));
      check("R8 vld high", int'(vld_o), 1);
    end

    // R7, R8: strobe low holds the last capture (all ones -> 100 / 111).
    apply(clean_word(2), 1'b0);
    check("R7 hold gray", int'(gray_o), 4);
    check("R7 hold bin",  int'(bin_o), 7);
    check("R8 vld low", int'(vld_o), 0);

    // R3, R4: every clean code with each single bit inverted.
    for (int k = 0; k <= N; k++) begin
      for (int j = 0; j < N; j++) begin
        logic [N-1:0] w;
        logic [B-1:0] diff;
        w = clean_word(k) ^ N'(1 << j);
        apply(w, 1'b1);
        check("R3 flipped gray", int'(gray_o), int'(ref_gray(w)));
        diff = gray_o ^ B'(k ^ (k >> 1));
        check("R4 one gray bit", int'($countones(diff) <= 1), 1);
        check("R6 flipped bin", int'(bin_o), int'(ref_bin(ref_gray(w))));
      end
    end

    // R3, R6, R7, R8: seeded random words and strobes.
    for (int r = 0; r < 400; r++) begin
      logic [N-1:0] w;
      logic s;
      w = N'($urandom);
      s = ($urandom % 4) != 0;
      apply(w, s);
      check("R3 random gray", int'(gray_o), int'(exp_gray));
      check("R6 random bin", int'(bin_o), int'(ref_bin(exp_gray)));
      check("R8 random vld", int'(vld_o), int'(s));
    end

    // R1: reset asserted mid-run clears the outputs.
    apply(clean_word(N), 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 midrun gray", int'(gray_o), 0);
    check("R1 midrun vld", int'(vld_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule